// File: doc/BRIEF.md
# Maskable Interrupt Request Gatherer

This block collects eight internal interrupt events and two external peripheral lines and merges them into one active-low interrupt request for a processor. Software sees a small register window: a write-only enable register and a read-only status register at the same address, plus one control register for each of the two peripheral channels. Status bits idle at 1 and drop to 0 when a request is pending. A latched status bit clears only when software writes 0 to its enable bit. That write also disables the source.

One internal status position is not a latch. It follows the "serial output empty" level directly. The two peripheral channels synchronise an asynchronous line and set a flag on its falling edge. The flag clears as a side effect of a read of the matching port data register. That read is signalled to this block by a strobe from the neighbouring port logic. The enable register has no reset value, so software must write it before it unmasks the processor.

Top module: `irq_gather`

## Requirements
- R1: Event input bit i maps to status and enable bit i. The order from bit 7 down to bit 0 is: break key, other key, serial byte received, serial output needs data, serial output empty (level), timer 4, timer 2, timer 1.
- R2: A read of address 0 returns the status register. Each bit reads 1 when idle and 0 when a request is pending. Reading it has no side effect.
- R3: While a source's enable bit is 0, its latched status bit reads 1 and strobes on its event input are ignored.
- R4: A one-cycle strobe on an enabled latched source makes its status bit read 0 from the cycle after the strobe.
- R5: A latched status bit stays 0 until 0 is written to its enable bit. After that write it reads 1. Writing 1 to the enable bit leaves a pending bit at 0.
- R6: Status bit 3 reads 0 while event input bit 3 (serial output empty) is 1, and reads 1 otherwise, whatever its enable bit holds.
- R7: irq_n is 0 exactly when an enabled status bit reads 0 (bit 3 included) or a peripheral flag is set with its enable at 1.
- R8: Address 1 (channel A) and address 2 (channel B) read back as flag in bit 7, enable in bit 0 and 0 in all other bits. Only bit 0 is writable. Address 3 reads 0.
- R9: Reset clears both peripheral enables and flags, and every latched status bit reads 1.
- R10: A falling edge on a peripheral line sets that channel's flag. The flag reads 1 after the third rising clock edge that follows the line change, and still reads 0 after the second.
- R11: A port-read strobe clears its channel's flag. If a falling edge sets the flag in the same cycle as the strobe, the flag stays set.
- R12: A set peripheral flag with its enable at 0 does not drive irq_n low. Setting the enable then drives irq_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 enable/status, 1 channel A control, 2 channel B control |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| src_evt | input | 8 | Internal events: one-cycle strobes, except bit 3, which is the serial-output-empty level |
| ext_line | input | 2 | Asynchronous peripheral interrupt lines (bit 0 channel A, bit 1 channel B), active on falling edge |
| port_rd | input | 2 | Strobes marking a read of the port A / port B data register |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench builds the block with its defaults: eight sources, the level source at bit 3, and a two-stage synchroniser. With only eight enable bits, every enable pattern (all 256) can be combined with several strobe patterns and both levels of the serial-empty input. The status word and irq_n are then compared against values computed bit by bit. The short synchroniser keeps the edge timing within a few cycles, so the bench can pin down the exact cycle the flag appears and line a port-read strobe up on the same edge as a new falling edge.

// File: rtl/irqg_pkg.sv
// Shared constants and the register address map for the interrupt gatherer.
package irqg_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned NUM_PER  = 2;
    localparam int unsigned PFLAG_BIT = 7;
    localparam int unsigned PEN_BIT   = 0;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MASKSTAT = 2'd0,
        ADR_PCTL_A   = 2'd1,
        ADR_PCTL_B   = 2'd2,
        ADR_SPARE    = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irqg_src_cell.sv
// One internal interrupt source: an enable flop and its active-low status.
// LATCHED=1: status latches low on a strobe while enabled and returns high
// when the enable is written to 0 (the clear takes effect on the same edge).
// LATCHED=0: status is the inverted live level on ev; enable does not touch it.
// Assumes strobes on ev are already synchronous and one cycle wide.
module irqg_src_cell #(
    parameter bit LATCHED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wval,
    input  logic ev,
    output logic en,
    output logic stat_n
);
    logic en_q;
    logic en_nxt;

    assign en_nxt = en_wr ? en_wval : en_q;

    // Enable bit: written by software only, deliberately left without reset.
    always_ff @(posedge clk) begin
        en_q <= en_nxt;
    end

    assign en = en_q;

    generate
        if (LATCHED) begin : g_latch
            logic stat_q;

            // Status latch: forced idle by a disabled enable, pulled low by a strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)       stat_q <= 1'b1;
                else if (!en_nxt) stat_q <= 1'b1;
                else if (ev)      stat_q <= 1'b0;
            end

            assign stat_n = stat_q;

            // R3: a disabled source reads idle
            assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !en_q |-> stat_q);
            // R4: an enabled strobe latches a pending request
            assert_strobe_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (en_q && !en_wr && ev) |=> !stat_q);
            // R5: a pending request holds until a zero is written to its enable
            assert_sticky_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!stat_q && !(en_wr && !en_wval)) |=> !stat_q);
        end else begin : g_live
            assign stat_n = ~ev;

            // R6: live bit reads pending whenever the level is high
            assert_live_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ev |-> !stat_n);
        end
    endgenerate
endmodule

// File: rtl/irqg_per_chan.sv
// One peripheral interrupt channel: a synchroniser for an asynchronous
// line, falling-edge detection, a flag cleared by a port-read strobe, and
// an enable bit. A new edge wins over a clearing read in the same cycle.
// Assumes the line idles high; the sync chain resets to 1 to avoid a false edge.
module irqg_per_chan #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic en_wr,
    input  logic en_wval,
    input  logic port_rd,
    output logic flag,
    output logic en
);
    localparam int unsigned SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            fall;
    logic            flag_q;
    logic            en_q;

    // Synchroniser chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[SH_W-2:0], line};
    end

    assign fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];

    // Flag: set on a synchronised falling edge, cleared by a port read.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (fall)    flag_q <= 1'b1;
        else if (port_rd) flag_q <= 1'b0;
    end

    // Channel enable: cleared at reset, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_wval;
    end

    assign flag = flag_q;
    assign en   = en_q;

    // R10: a detected falling edge raises the flag
    assert_edge_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> flag_q);
    // R11: a port read without a coinciding edge clears the flag
    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !fall) |=> !flag_q);
    // R9: the first cycle out of reset has enable and flag cleared
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!en_q && !flag_q));
endmodule

// File: rtl/irq_gather.sv
// Interrupt request gatherer top. Builds NSRC source cells (one of them a
// live level at TX_BIT) and two peripheral channels, decodes the register
// window and merges everything into the active-low irq_n.
// Assumes NSRC equals the register data width; irq_n is combinational from
// state and from the live level input.
module irq_gather
    import irqg_pkg::*;
#(
    parameter int unsigned NSRC        = 8,
    parameter int unsigned TX_BIT      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NSRC-1:0]      src_evt,
    input  logic [NUM_PER-1:0]   ext_line,
    input  logic [NUM_PER-1:0]   port_rd,
    output logic                 irq_n
);
    logic [NSRC-1:0]    en_v;
    logic [NSRC-1:0]    stat_v;
    logic [NUM_PER-1:0] pen;
    logic [NUM_PER-1:0] pflag;
    logic               mask_wr;
    logic [NUM_PER-1:0] pctl_wr;
    logic               src_req;
    logic               per_req;

    assign mask_wr    = reg_we && (reg_addr == ADR_MASKSTAT);
    assign pctl_wr[0] = reg_we && (reg_addr == ADR_PCTL_A);
    assign pctl_wr[1] = reg_we && (reg_addr == ADR_PCTL_B);

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            irqg_src_cell #(
                .LATCHED (gi != TX_BIT)
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_wr   (mask_wr),
                .en_wval (reg_wdata[gi]),
                .ev      (src_evt[gi]),
                .en      (en_v[gi]),
                .stat_n  (stat_v[gi])
            );
        end

        for (gi = 0; gi < NUM_PER; gi++) begin : g_per
            irqg_per_chan #(
                .SYNC_STAGES (SYNC_STAGES)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .line    (ext_line[gi]),
                .en_wr   (pctl_wr[gi]),
                .en_wval (reg_wdata[PEN_BIT]),
                .port_rd (port_rd[gi]),
                .flag    (pflag[gi]),
                .en      (pen[gi])
            );
        end
    endgenerate

    // Read mux: status word or a channel control byte, no read side effects.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            ADR_MASKSTAT: reg_rdata = stat_v;
            ADR_PCTL_A: begin
                reg_rdata[PFLAG_BIT] = pflag[0];
                reg_rdata[PEN_BIT]   = pen[0];
            end
            ADR_PCTL_B: begin
                reg_rdata[PFLAG_BIT] = pflag[1];
                reg_rdata[PEN_BIT]   = pen[1];
            end
            default: reg_rdata = '0;
        endcase
    end

    assign src_req = |(en_v & ~stat_v);
    assign per_req = |(pen & pflag);
    assign irq_n   = ~(src_req | per_req);

    // R12: an enabled, set peripheral flag always pulls the request low
    assert_per_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> !irq_n);
    // R7: with nothing enabled and pending, the request is released
    assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_v & ~stat_v) == '0 && (pen & pflag) == '0) |-> irq_n);
endmodule

// File: tb/irq_gather_tb.sv
`timescale 1ns/100ps
module irq_gather_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] src_evt = 8'h00;
    logic [1:0] ext_line = 2'b11;
    logic [1:0] port_rd = 2'b00;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_gather u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_evt   (src_evt),
        .ext_line  (ext_line),
        .port_rd   (port_rd),
        .irq_n     (irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive a register write for one clock, starting at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Sample a register just after the current falling edge.
    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] s, exp_st;
        logic       lvl;
        logic       exp_irq_n;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R8 / R2: reset state of control and status registers
        peek(2'd1, rd); check("R9 ctrlA after reset", rd, 8'h00);
        peek(2'd2, rd); check("R9 ctrlB after reset", rd, 8'h00);
        peek(2'd0, rd); check("R2 R9 status after reset", rd, 8'hFF);
        peek(2'd3, rd); check("R8 spare address", rd, 8'h00);

        // R1 R3 R4 R6 R7: every enable pattern against several strobe patterns
        for (int e = 0; e < 256; e++) begin
            for (int p = 0; p < 4; p++) begin
                case (p)
                    0: s = 8'hFF;
                    1: s = 8'h00;
                    2: s = ~8'(e);
                    default: s = 8'h5A ^ 8'(e);
                endcase
                lvl = e[1] ^ p[0];
                src_evt = {4'b0000, lvl, 3'b000};
                wr(2'd0, 8'h00);
                wr(2'd0, 8'(e));
                src_evt = (s & 8'hF7) | {4'b0000, lvl, 3'b000};
                @(negedge clk);
                src_evt = {4'b0000, lvl, 3'b000};
                for (int i = 0; i < 8; i++) begin
                    if (i == 3) exp_st[i] = ~lvl;
                    else        exp_st[i] = ~(e[i] & s[i]);
                end
                exp_irq_n = ~(|(8'(e) & ~exp_st));
                peek(2'd0, rd);
                check("R1 R3 R4 R6 status sweep", rd, exp_st);
                check("R7 irq_n sweep", {7'd0, irq_n}, {7'd0, exp_irq_n});
            end
        end
        src_evt = 8'h00;

        // R5: pending bit 5 is sticky until its enable is written to 0
        wr(2'd0, 8'h00);
        wr(2'd0, 8'hFF);
        @(negedge clk); src_evt = 8'h20;
        @(negedge clk); src_evt = 8'h00;
        repeat (3) @(negedge clk);
        peek(2'd0, rd); check("R5 pending held", rd, 8'hDF);
        wr(2'd0, 8'hFF);
        peek(2'd0, rd); check("R5 rewrite of 1 keeps pending", rd, 8'hDF);
        check("R7 irq low while pending", {7'd0, irq_n}, 8'h00);
        wr(2'd0, 8'hDF);
        peek(2'd0, rd); check("R5 zero write clears", rd, 8'hFF);
        wr(2'd0, 8'hFF);
        peek(2'd0, rd); check("R5 stays clear after re-enable", rd, 8'hFF);

        // R3: strobe while disabled leaves no trace after enabling
        wr(2'd0, 8'h00);
        @(negedge clk); src_evt = 8'h81;
        @(negedge clk); src_evt = 8'h00;
        wr(2'd0, 8'hF7);
        peek(2'd0, rd); check("R3 ignored strobe", rd, 8'hFF);
        check("R3 irq high", {7'd0, irq_n}, 8'h01);

        // R6: live bit ignores its enable bit
        src_evt = 8'h08;
        wr(2'd0, 8'h00);
        peek(2'd0, rd); check("R6 live bit with enable 0", rd, 8'hF7);
        check("R7 live bit masked", {7'd0, irq_n}, 8'h01);
        wr(2'd0, 8'h08);
        check("R7 live bit enabled", {7'd0, irq_n}, 8'h00);
        src_evt = 8'h00;
        #1;
        check("R6 live bit released", {7'd0, irq_n}, 8'h01);
        wr(2'd0, 8'h00);

        // R8: only the enable bit of a control register is writable
        wr(2'd1, 8'hFF);
        peek(2'd1, rd); check("R8 ctrlA write FF", rd, 8'h01);

        // R10: flag timing on channel A
        reg_addr = 2'd1;
        @(negedge clk); ext_line[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        peek(2'd1, rd); check("R10 no flag after 2 edges", rd, 8'h01);
        @(negedge clk);
        peek(2'd1, rd); check("R10 flag after 3 edges", rd, 8'h81);
        check("R7 irq from channel A", {7'd0, irq_n}, 8'h00);

        // R11 / R12: clear A, set B while disabled, then enable B
        @(negedge clk); port_rd = 2'b01;
        @(negedge clk); port_rd = 2'b00;
        peek(2'd1, rd); check("R11 port read clears A", rd, 8'h01);
        check("R11 irq released", {7'd0, irq_n}, 8'h01);
        ext_line[1] = 1'b0;
        repeat (4) @(negedge clk);
        peek(2'd2, rd); check("R12 B flag set, disabled", rd, 8'h80);
        check("R12 disabled flag no irq", {7'd0, irq_n}, 8'h01);
        wr(2'd2, 8'h01);
        peek(2'd2, rd); check("R12 B enabled", rd, 8'h81);
        check("R12 irq after enable", {7'd0, irq_n}, 8'h00);

        // R11: new edge on the same edge as a clearing read keeps the flag
        ext_line[1] = 1'b1;
        repeat (4) @(negedge clk);
        ext_line[1] = 1'b0;
        @(negedge clk);
        @(negedge clk); port_rd = 2'b10;
        @(negedge clk); port_rd = 2'b00;
        peek(2'd2, rd); check("R11 edge beats read", rd, 8'h81);
        @(negedge clk); port_rd = 2'b10;
        @(negedge clk); port_rd = 2'b00;
        peek(2'd2, rd); check("R11 plain read clears B", rd, 8'h01);
        check("R7 irq idle at end", {7'd0, irq_n}, 8'h01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule